// File: doc/BRIEF.md
# Variable-Page-Size Translation Buffer

This block is a small, fully associative address translation buffer. It has sixteen entries, and each entry holds its own page size. A lookup presents a 32-bit effective address, an address-space bit and an 8-bit process tag. In the same cycle the block answers with hit, miss and multi-hit indications, a 36-bit real address, the storage attribute bits of the selected entry and its access permissions. The block is purely combinational from the lookup inputs to the result outputs.

Software fills the buffer one entry at a time. It loads four descriptor words into staging registers and then pulses a commit strobe, which copies the staged words into the entry that the first word selects. A separate invalidate-all strobe drops every entry that is not marked as protected. Matching compares a different number of upper address bits for each page size. An entry tagged with process tag zero serves every process. The real address is built from an extended page nibble, the upper page bits of the entry and the untranslated page offset of the effective address.

Top module: `vpage_tlb`

## Requirements
- R1: After reset every entry is invalid, so every lookup gives hit=0, miss=1, multiHit=0, realAddr=0, attrOut=0 and permOut=0.
- R2: An entry matches only when all of these hold: its valid bit is 1, its space bit equals lkSpace, its process tag satisfies R3, and its page number satisfies R4.
- R3: An entry whose process tag is zero matches any lkPid. Any other tag must equal lkPid.
- R4: Size code c in 1..9 selects a page of 4^c KB, so the page offset is 10+2c bits wide and only lkEa bits above the offset are compared with the entry page. Codes 0 and 10..15 never match.
- R5: On a hit, realAddr = {extended page (4 bits), real page bits above the offset, lkEa offset bits}. Real page bits that lie inside the offset are ignored.
- R6: On a hit, attrOut and permOut show the selected entry's attribute and permission fields. On a miss, realAddr, attrOut and permOut are all zero.
- R7: When two or more entries match, multiHit=1 and all outputs come from the lowest-indexed matching entry.
- R8: With descLoad=1, descWord is written into staging word descSel at the clock edge. A commit writes the staged words into the entry given by word0[19:16], but only if word0[28]=1; with word0[28]=0 a commit changes nothing. The field layout is: word1 valid[31], protect[30], tag[23:16], space[12], size code[11:8]; word2 page[31:12], attributes[4:0]; word3 real page[31:12], extended page[11:8], permissions[5:0].
- R9: invAll clears the valid bit of every entry whose protect bit is 0. Protected entries keep matching.
- R10: When commit and invAll occur in the same cycle, the committed entry takes the newly written contents, valid bit included.
- R11: miss is always the inverse of hit, and multiHit=1 only while hit=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkEa | input | 32 | Effective address to translate |
| lkSpace | input | 1 | Address-space bit of the lookup |
| lkPid | input | 8 | Process tag of the lookup |
| hit | output | 1 | At least one entry matches |
| miss | output | 1 | No entry matches |
| multiHit | output | 1 | More than one entry matches |
| realAddr | output | 36 | Translated real address, zero on a miss |
| attrOut | output | 5 | Attribute bits of the selected entry |
| permOut | output | 6 | Permission bits of the selected entry |
| descWord | input | 32 | Descriptor word to stage |
| descSel | input | 2 | Staging word index |
| descLoad | input | 1 | Stage descWord into word descSel |
| commit | input | 1 | Write the staged descriptor into an entry |
| invAll | input | 1 | Invalidate all unprotected entries |

## Verification
The bench probes one address on each side of a page boundary for both the smallest and the largest page. A design with the wrong compare mask would hit on the neighbouring page, or would fail to translate offsets near the top of a large page. It places overlapping pages of different sizes so that the lowest index must win; a reversed priority encoder would then return the other entry's real address. It also checks that a global tag matches any process tag, that a commit with the array bit clear leaves the old entry intact, that protected entries survive a bulk invalidate, and that a commit in the same cycle as an invalidate still wins. Each of these faults would show up as a wrong hit flag or a wrong translated address.

// File: rtl/vpage_tlb_pkg.sv
package vpage_tlb_pkg;
  localparam int EA_W     = 32;
  localparam int PID_W    = 8;
  localparam int MIN_OFF  = 12;
  localparam int PAGE_W   = EA_W - MIN_OFF;
  localparam int XRP_W    = 4;
  localparam int RA_W     = XRP_W + EA_W;
  localparam int ATTR_W   = 5;
  localparam int PERM_W   = 6;
  localparam int CODE_W   = 4;
  localparam int CODE_MIN = 1;
  localparam int CODE_MAX = 9;
  localparam int ARRAY_BIT = 28;
  localparam int IDX_LSB  = 16;

  typedef struct packed {
    logic              valid;
    logic              prot;
    logic [PID_W-1:0]  pid;
    logic              space;
    logic [CODE_W-1:0] code;
    logic [PAGE_W-1:0] epn;
    logic [ATTR_W-1:0] attr;
    logic [PAGE_W-1:0] rpn;
    logic [XRP_W-1:0]  xrpn;
    logic [PERM_W-1:0] perm;
  } tlbEntry_t;

  typedef struct packed {
    logic wrEn;
    logic invAll;
  } tlbCtl_t;

  function automatic logic codeOk(input logic [CODE_W-1:0] code);
    return (code >= CODE_W'(CODE_MIN)) && (code <= CODE_W'(CODE_MAX));
  endfunction

  // low bits of the address that pass through untranslated
  function automatic logic [EA_W-1:0] offMask(input logic [CODE_W-1:0] code);
    logic [EA_W-1:0] m;
    m = '0;
    for (int k = CODE_MIN; k <= CODE_MAX; k++) begin
      if (code == CODE_W'(k)) m = (EA_W'(1) << (10 + 2 * k)) - EA_W'(1);
    end
    return m;
  endfunction
endpackage

// File: rtl/vpage_tlb_ctrl.sv
module vpage_tlb_ctrl
  import vpage_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [EA_W-1:0]   descWord,
  input  logic [1:0]        descSel,
  input  logic              descLoad,
  input  logic              commit,
  input  logic              invAll,
  output tlbCtl_t           ctl,
  output logic [IDX_W-1:0]  wrIdx,
  output tlbEntry_t         newEntry
);
  localparam int WORDS = 4;

  logic [EA_W-1:0] stage [WORDS];
  logic            unusedStage;

  for (genvar w = 0; w < WORDS; w++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) stage[w] <= '0;
      else if (descLoad && descSel == 2'(w)) stage[w] <= descWord;
    end
  end

  always_comb begin
    newEntry.valid = stage[1][31];
    newEntry.prot  = stage[1][30];
    newEntry.pid   = stage[1][23:16];
    newEntry.space = stage[1][12];
    newEntry.code  = stage[1][11:8];
    newEntry.epn   = stage[2][EA_W-1:MIN_OFF];
    newEntry.attr  = stage[2][ATTR_W-1:0];
    newEntry.rpn   = stage[3][EA_W-1:MIN_OFF];
    newEntry.xrpn  = stage[3][11:8];
    newEntry.perm  = stage[3][PERM_W-1:0];
  end

  assign wrIdx      = stage[0][IDX_LSB +: IDX_W];
  assign ctl.wrEn   = commit && stage[0][ARRAY_BIT];
  assign ctl.invAll = invAll;
  assign unusedStage = ^{stage[0], stage[1], stage[2], stage[3]};
endmodule

// File: rtl/vpage_tlb_dp.sv
module vpage_tlb_dp
  import vpage_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlbCtl_t            ctl,
  input  logic [IDX_W-1:0]   wrIdx,
  input  tlbEntry_t          newEntry,
  input  logic [EA_W-1:0]    lkEa,
  input  logic               lkSpace,
  input  logic [PID_W-1:0]   lkPid,
  output logic               hit,
  output logic               multiHit,
  output logic [RA_W-1:0]    realAddr,
  output logic [ATTR_W-1:0]  attrOut,
  output logic [PERM_W-1:0]  permOut,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] protVec
);
  tlbEntry_t          ent [ENTRIES];
  logic [ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0]   selIdx;
  tlbEntry_t          sel;
  logic [EA_W-1:0]    selMask;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic [EA_W-1:0] m;
    logic            pidOk;
    logic            pageOk;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ent[i] <= '0;
      end else begin
        if (ctl.invAll && !ent[i].prot) ent[i].valid <= 1'b0;
        if (ctl.wrEn && wrIdx == IDX_W'(i)) ent[i] <= newEntry;
      end
    end

    assign m        = offMask(ent[i].code);
    assign pidOk    = (ent[i].pid == '0) || (ent[i].pid == lkPid);
    assign pageOk   = ((lkEa ^ {ent[i].epn, {MIN_OFF{1'b0}}}) & ~m) == '0;
    assign matchVec[i] = ent[i].valid && codeOk(ent[i].code) &&
                         (ent[i].space == lkSpace) && pidOk && pageOk;
    assign validVec[i] = ent[i].valid;
    assign protVec[i]  = ent[i].prot;
  end

  // lowest index wins
  always_comb begin
    selIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) selIdx = IDX_W'(i);
    end
  end

  assign sel      = ent[selIdx];
  assign selMask  = offMask(sel.code);
  assign hit      = |matchVec;
  assign multiHit = (matchVec & (matchVec - ENTRIES'(1))) != '0;

  always_comb begin
    if (hit) begin
      realAddr = {sel.xrpn, ({sel.rpn, {MIN_OFF{1'b0}}} & ~selMask) | (lkEa & selMask)};
      attrOut  = sel.attr;
      permOut  = sel.perm;
    end else begin
      realAddr = '0;
      attrOut  = '0;
      permOut  = '0;
    end
  end
endmodule

// File: rtl/vpage_tlb.sv
module vpage_tlb
  import vpage_tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       lkEa,
  input  logic              lkSpace,
  input  logic [7:0]        lkPid,
  output logic              hit,
  output logic              miss,
  output logic              multiHit,
  output logic [35:0]       realAddr,
  output logic [4:0]        attrOut,
  output logic [5:0]        permOut,
  input  logic [31:0]       descWord,
  input  logic [1:0]        descSel,
  input  logic              descLoad,
  input  logic              commit,
  input  logic              invAll
);
  localparam int IDX_W = $clog2(ENTRIES);

  tlbCtl_t            ctl;
  logic [IDX_W-1:0]   wrIdx;
  tlbEntry_t          newEntry;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] protVec;

  vpage_tlb_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .descWord(descWord), .descSel(descSel),
    .descLoad(descLoad), .commit(commit), .invAll(invAll),
    .ctl(ctl), .wrIdx(wrIdx), .newEntry(newEntry)
  );

  vpage_tlb_dp #(.ENTRIES(ENTRIES)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrIdx(wrIdx), .newEntry(newEntry),
    .lkEa(lkEa), .lkSpace(lkSpace), .lkPid(lkPid),
    .hit(hit), .multiHit(multiHit), .realAddr(realAddr),
    .attrOut(attrOut), .permOut(permOut),
    .validVec(validVec), .protVec(protVec)
  );

  assign miss = ~hit;
endmodule

// File: rtl/vpage_tlb_chk.sv
module vpage_tlb_chk #(
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic [31:0]        lkEa,
  input logic               hit,
  input logic               miss,
  input logic               multiHit,
  input logic [35:0]        realAddr,
  input logic [4:0]         attrOut,
  input logic [5:0]         permOut,
  input logic               commit,
  input logic               invAll,
  input logic [ENTRIES-1:0] validVec,
  input logic [ENTRIES-1:0] protVec
);
  // R11
  multi_implies_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    multiHit |-> hit && !miss);

  // R6
  miss_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (realAddr == '0) && (attrOut == '0) && (permOut == '0));

  // R5
  offset_passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> realAddr[11:0] == lkEa[11:0]);

  // R9
  inv_clears_unprot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (invAll && !commit) |=> (validVec & ~protVec) == '0);

  // R8
  valid_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!invAll && !commit) |=> $stable(validVec));

  // R1
  reset_empty_chk: assert property (@(posedge clk)
    !rstN |=> validVec == '0);
endmodule

bind vpage_tlb vpage_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rstN(rstN), .lkEa(lkEa), .hit(hit), .miss(miss),
  .multiHit(multiHit), .realAddr(realAddr), .attrOut(attrOut),
  .permOut(permOut), .commit(commit), .invAll(invAll),
  .validVec(validVec), .protVec(protVec)
);

// File: tb/vpage_tlb_tb.sv
`timescale 1ns/1ps
module vpage_tlb_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lkEa = '0;
  logic        lkSpace = 1'b0;
  logic [7:0]  lkPid = '0;
  logic        hit, miss, multiHit;
  logic [35:0] realAddr;
  logic [4:0]  attrOut;
  logic [5:0]  permOut;
  logic [31:0] descWord = '0;
  logic [1:0]  descSel = '0;
  logic        descLoad = 1'b0;
  logic        commit = 1'b0;
  logic        invAll = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vpage_tlb u_dut (
    .clk(clk), .rstN(rstN), .lkEa(lkEa), .lkSpace(lkSpace), .lkPid(lkPid),
    .hit(hit), .miss(miss), .multiHit(multiHit), .realAddr(realAddr),
    .attrOut(attrOut), .permOut(permOut), .descWord(descWord),
    .descSel(descSel), .descLoad(descLoad), .commit(commit), .invAll(invAll)
  );

  // reference copy of the entries
  bit        mV[16], mP[16], mS[16];
  bit [7:0]  mPid[16];
  bit [3:0]  mC[16], mX[16];
  bit [19:0] mEpn[16], mRpn[16];
  bit [4:0]  mAttr[16];
  bit [5:0]  mPerm[16];

  function automatic bit [31:0] maskOf(bit [3:0] c);
    if (c < 1 || c > 9) return 32'h0;
    return (32'd1 << (10 + 2 * c)) - 32'd1;
  endfunction

  function automatic bit refMatch(int i, bit [31:0] ea, bit sp, bit [7:0] pid);
    bit [31:0] m;
    if (!mV[i] || mC[i] < 1 || mC[i] > 9) return 1'b0;
    if (mS[i] != sp) return 1'b0;
    if (mPid[i] != 0 && mPid[i] != pid) return 1'b0;
    m = maskOf(mC[i]);
    return ((ea ^ {mEpn[i], 12'h0}) & ~m) == 0;
  endfunction

  task automatic lookup(bit [31:0] ea, bit sp, bit [7:0] pid, string req);
    int n;
    int sel;
    bit [35:0] eRa;
    bit [4:0]  eAt;
    bit [5:0]  ePm;
    bit [31:0] m;
    @(negedge clk);
    lkEa = ea; lkSpace = sp; lkPid = pid;
    #1;
    n = 0; sel = -1;
    for (int i = 0; i < 16; i++) if (refMatch(i, ea, sp, pid)) begin
      n++;
      if (sel < 0) sel = i;
    end
    eRa = '0; eAt = '0; ePm = '0;
    if (sel >= 0) begin
      m = maskOf(mC[sel]);
      eRa = {mX[sel], ({mRpn[sel], 12'h0} & ~m) | (ea & m)};
      eAt = mAttr[sel]; ePm = mPerm[sel];
    end
    checks++;
    if (hit !== (n > 0) || miss !== (n == 0) || multiHit !== (n > 1) ||
        realAddr !== eRa || attrOut !== eAt || permOut !== ePm) begin
      fails++;
      $display("FAIL %s ea=%h: got hit=%b multi=%b ra=%h at=%h pm=%h exp hit=%b multi=%b ra=%h at=%h pm=%h",
               req, ea, hit, multiHit, realAddr, attrOut, permOut,
               n > 0, n > 1, eRa, eAt, ePm);
    end
  endtask

  task automatic stageWord(bit [1:0] s, bit [31:0] w);
    @(negedge clk);
    descSel = s; descWord = w; descLoad = 1'b1;
    @(negedge clk);
    descLoad = 1'b0;
  endtask

  // R8 field layout
  task automatic writeEntry(bit arr, int idx, bit v, bit p, bit [7:0] pid, bit sp,
                            bit [3:0] c, bit [19:0] epn, bit [4:0] at,
                            bit [19:0] rpn, bit [3:0] x, bit [5:0] pm, bit inv);
    stageWord(2'd0, (32'(arr) << 28) | (32'(idx) << 16));
    stageWord(2'd1, {v, p, 6'h0, pid, 3'h0, sp, c, 8'h0});
    stageWord(2'd2, {epn, 7'h0, at});
    stageWord(2'd3, {rpn, x, 2'h0, pm});
    @(negedge clk);
    commit = 1'b1; invAll = inv;
    @(negedge clk);
    commit = 1'b0; invAll = 1'b0;
    if (inv) for (int i = 0; i < 16; i++) if (!mP[i]) mV[i] = 1'b0;
    if (arr) begin
      mV[idx] = v; mP[idx] = p; mPid[idx] = pid; mS[idx] = sp; mC[idx] = c;
      mEpn[idx] = epn; mAttr[idx] = at; mRpn[idx] = rpn; mX[idx] = x; mPerm[idx] = pm;
    end
  endtask

  task automatic invalidateAll();
    @(negedge clk);
    invAll = 1'b1;
    @(negedge clk);
    invAll = 1'b0;
    for (int i = 0; i < 16; i++) if (!mP[i]) mV[i] = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed);
    for (int i = 0; i < 16; i++) begin
      mV[i] = 0; mP[i] = 0; mS[i] = 0; mPid[i] = 0; mC[i] = 0;
      mX[i] = 0; mEpn[i] = 0; mRpn[i] = 0; mAttr[i] = 0; mPerm[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    lookup(32'h0000_0000, 1'b0, 8'h00, "R1");
    lookup(32'hffff_f123, 1'b1, 8'h05, "R1");

    // R2 R5 small page with a private tag
    writeEntry(1, 3, 1, 0, 8'h05, 1, 4'd1, 20'hd0010, 5'h0a, 20'h12345, 4'ha, 6'h15, 0);
    lookup(32'hd001_0abc, 1'b1, 8'h05, "R5");
    lookup(32'hd001_0abc, 1'b0, 8'h05, "R2");
    lookup(32'hd001_0abc, 1'b1, 8'h06, "R2");
    lookup(32'hd001_1abc, 1'b1, 8'h05, "R4");
    lookup(32'hd000_ffff, 1'b1, 8'h05, "R4");

    // R3 R4 R5 large global page, stray low page bits in the entry
    writeEntry(1, 5, 1, 0, 8'h00, 0, 4'd9, 20'h80000, 5'h1f, 20'h3ffff, 4'h1, 6'h3f, 0);
    lookup(32'h8abc_def0, 1'b0, 8'h77, "R3");
    lookup(32'h8fff_ffff, 1'b0, 8'h00, "R4");
    lookup(32'h9000_0000, 1'b0, 8'h00, "R4");

    // R4 unused size codes never hit
    writeEntry(1, 7, 1, 0, 8'h00, 0, 4'd0, 20'h40000, 5'h01, 20'h00001, 4'h0, 6'h01, 0);
    writeEntry(1, 8, 1, 0, 8'h00, 0, 4'd12, 20'h40000, 5'h01, 20'h00001, 4'h0, 6'h01, 0);
    lookup(32'h4000_0010, 1'b0, 8'h00, "R4");

    // R7 overlapping pages, lowest index wins
    writeEntry(1, 2, 1, 0, 8'h00, 0, 4'd5, 20'h8ab00, 5'h02, 20'h55500, 4'h7, 6'h02, 0);
    lookup(32'h8abc_def0, 1'b0, 8'h33, "R7");

    // R8 commit with the array bit clear changes nothing
    writeEntry(0, 2, 1, 0, 8'h00, 0, 4'd1, 20'h11111, 5'h03, 20'h22222, 4'h3, 6'h03, 0);
    lookup(32'h8abc_def0, 1'b0, 8'h33, "R8");
    lookup(32'h1111_1000, 1'b0, 8'h00, "R8");

    // R9 protected entry survives a bulk invalidate
    writeEntry(1, 9, 1, 1, 8'h00, 1, 4'd2, 20'hf8000, 5'h0e, 20'hf8000, 4'h0, 6'h2a, 0);
    invalidateAll();
    lookup(32'hf800_3ff0, 1'b1, 8'h09, "R9");
    lookup(32'h8abc_def0, 1'b0, 8'h00, "R9");
    lookup(32'hd001_0abc, 1'b1, 8'h05, "R9");

    // R10 commit and invalidate together
    writeEntry(1, 4, 1, 0, 8'h00, 0, 4'd3, 20'h20000, 5'h04, 20'h70000, 4'h2, 6'h04, 1);
    lookup(32'h2000_0fff, 1'b0, 8'h00, "R10");

    // R2..R11 random mix
    for (int it = 0; it < 1500; it++) begin
      int op;
      int e;
      bit [31:0] ea;
      op = $urandom_range(99);
      if (op < 20) begin
        writeEntry(op < 2 ? 1'b0 : 1'b1, $urandom_range(15), $urandom_range(9) != 0,
                   $urandom_range(5) == 0, 8'($urandom_range(2)), 1'($urandom),
                   4'($urandom_range(10)), 20'($urandom), 5'($urandom),
                   20'($urandom), 4'($urandom), 6'($urandom), $urandom_range(30) == 0);
      end else if (op < 23) begin
        invalidateAll();
      end else begin
        e = $urandom_range(15);
        ea = {mEpn[e], 12'h0} ^ (32'($urandom) & maskOf(mC[e] == 0 ? 4'd1 : mC[e]));
        if ($urandom_range(7) == 0) ea = $urandom;
        lookup(ea, $urandom_range(3) == 0 ? ~mS[e] : mS[e],
               8'($urandom_range(2)), "R11");
      end
    end

    done = 1'b1;
    summary();
  end
endmodule